// File: doc/BRIEF.md
# Oscillator Warm-Up and PLL Lock Timer

This block times the settling interval after an oscillator is switched on, for example when the device leaves a clock-stopped standby state or moves from the low-speed clock to the main clock. One counter, clocked by the selected input clock, measures two intervals at once. The first is the oscillator warm-up, whose length is chosen by a 2-bit field. The second is the PLL lock-up, whose length is chosen by a 1-bit field. Both intervals start from the same start event.

Two status flags report progress. The warm-up-end flag is cleared when a run starts and set when the warm-up length has elapsed. Software polls it to see both the start and the end of warm-up. The lock-busy flag is set when a run starts and clears when the lock length has elapsed. When the PLL is bypassed, it clears when warm-up completes instead. A one-cycle done pulse goes to the standby controller once the longer of the two intervals has run out.

While a run is active, a start request is refused. A write to the warm-up field is also refused during a run, and that write sets a sticky error bit.

Top module: `osc_warmup_timer`

## Requirements
- R1: After reset, wu_end, lock_busy, done and cfg_err are 0, wu_sel_q is 2'b10 and lk_sel_q is 0.
- R2: When the block is idle, a start request on sw_start or hw_start begins a run at that clock edge. After that edge, wu_end reads 0 and lock_busy reads 1. The field values and pll_bypass are captured at that edge.
- R3: Warm-up codes 2'b01, 2'b10 and 2'b11 select 2^WU_E1, 2^WU_E2 and 2^WU_E3 input clock cycles. wu_end goes to 1 at the Nth rising edge after the start edge, where N is the selected length.
- R4: Warm-up code 2'b00 selects 2^LS_E low-speed ticks. In this mode the counter advances only on edges where ls_tick is 1, and the lock length is counted in the same ticks. Under any other code, ls_tick has no effect.
- R5: Lock code 0 selects 2^LK_E0 counts and lock code 1 selects 2^LK_E1 counts. With pll_bypass at 0, lock_busy clears at the edge where the lock length is reached.
- R6: With pll_bypass at 1, lock_busy clears at the same edge at which wu_end is set.
- R7: done is a pulse of exactly one cycle. It is issued at the edge where the larger of the warm-up length and the effective lock length is reached, and the block then returns to idle.
- R8: A start request during a run is ignored: the run keeps its timing and wu_end is not cleared.
- R9: A warm-up field write during a run is ignored and sets cfg_err. cfg_err stays 1 until reset. A write while idle updates wu_sel_q and leaves cfg_err unchanged.
- R10: After done, wu_end stays 1 and lock_busy stays 0 until the next accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Selected input clock that is being counted |
| rst_n | input | 1 | Active-low asynchronous reset |
| ls_tick | input | 1 | One-cycle strobe per low-speed clock period |
| pll_bypass | input | 1 | 1 when the PLL is not in the clock path |
| sw_start | input | 1 | Software warm-up start request |
| hw_start | input | 1 | Start request from the standby controller |
| wu_sel_we | input | 1 | Write strobe for the warm-up length field |
| wu_sel_wd | input | 2 | Warm-up length code to write |
| lk_sel_we | input | 1 | Write strobe for the lock length field |
| lk_sel_wd | input | 1 | Lock length code to write |
| wu_sel_q | output | 2 | Current warm-up length code |
| lk_sel_q | output | 1 | Current lock length code |
| wu_end | output | 1 | Warm-up finished flag |
| lock_busy | output | 1 | Lock-up in progress flag |
| done | output | 1 | One-cycle completion pulse to the standby controller |
| cfg_err | output | 1 | Sticky flag for a refused warm-up field write |

## Verification
A wrong count or a wrong captured length shows up at the ports as wu_end, lock_busy or done moving on the wrong edge. The bench sees this within one cycle of the expected edge, because it records the exact edge count of each transition. A missing guard on start shows up as wu_end dropping in the middle of a run, or as done arriving late. A missing guard on field writes shows up on wu_sel_q and cfg_err in the cycle after the write. A low-speed path that is selected wrongly shows up as intervals that are stretched or left unstretched by a factor equal to the tick period.

// File: rtl/wut_pkg.sv
package wut_pkg;
   typedef enum logic [1:0] {
      WU_LOWSPD = 2'b00,
      WU_SHORT  = 2'b01,
      WU_MID    = 2'b10,
      WU_LONG   = 2'b11
   } wu_code_e;

   function automatic int unsigned max2(input int unsigned a, input int unsigned b);
      return (a > b) ? a : b;
   endfunction
endpackage

// File: rtl/wut_cfg.sv
module wut_cfg #(
   parameter logic [1:0] WU_RST = 2'b10,
   parameter logic       LK_RST = 1'b0
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       busy,
   input  logic       wu_we,
   input  logic [1:0] wu_wd,
   input  logic       lk_we,
   input  logic       lk_wd,
   output logic [1:0] wu_q,
   output logic       lk_q,
   output logic       err_q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wu_q  <= WU_RST;
         lk_q  <= LK_RST;
         err_q <= 1'b0;
      end else begin
         if (wu_we) begin
            if (busy) err_q <= 1'b1;
            else      wu_q  <= wu_wd;
         end
         if (lk_we) lk_q <= lk_wd;
      end
   end
endmodule

// File: rtl/wut_len.sv
module wut_len #(
   parameter int unsigned WU_E1 = 8,
   parameter int unsigned WU_E2 = 14,
   parameter int unsigned WU_E3 = 16,
   parameter int unsigned LK_E0 = 16,
   parameter int unsigned LK_E1 = 12,
   parameter int unsigned LS_E  = 2,
   parameter bit          LS_ENABLE = 1'b1,
   parameter int unsigned CW    = 17
) (
   input  logic [1:0]    wu_code,
   input  logic          lk_code,
   input  logic          bypass,
   output logic [CW-1:0] wu_len,
   output logic [CW-1:0] lk_len,
   output logic [CW-1:0] end_len,
   output logic          slow
);
   import wut_pkg::*;
   localparam logic [CW-1:0] LEN_W1 = CW'(64'd1 << WU_E1);
   localparam logic [CW-1:0] LEN_W2 = CW'(64'd1 << WU_E2);
   localparam logic [CW-1:0] LEN_W3 = CW'(64'd1 << WU_E3);
   localparam logic [CW-1:0] LEN_L0 = CW'(64'd1 << LK_E0);
   localparam logic [CW-1:0] LEN_L1 = CW'(64'd1 << LK_E1);
   localparam logic [CW-1:0] LEN_LS = CW'(64'd1 << LS_E);

   logic [CW-1:0] lk_raw;

   generate
      if (LS_ENABLE) begin : g_ls
         assign slow = (wu_code == WU_LOWSPD);
         always_comb begin
            unique case (wu_code)
               WU_LOWSPD: wu_len = LEN_LS;
               WU_SHORT:  wu_len = LEN_W1;
               WU_MID:    wu_len = LEN_W2;
               default:   wu_len = LEN_W3;
            endcase
         end
      end else begin : g_nols
         assign slow = 1'b0;
         always_comb begin
            unique case (wu_code)
               WU_MID:  wu_len = LEN_W2;
               WU_LONG: wu_len = LEN_W3;
               default: wu_len = LEN_W1;
            endcase
         end
      end
   endgenerate

   assign lk_raw  = lk_code ? LEN_L1 : LEN_L0;
   assign lk_len  = bypass ? wu_len : lk_raw;
   assign end_len = (lk_len > wu_len) ? lk_len : wu_len;
endmodule

// File: rtl/wut_cnt.sv
module wut_cnt #(
   parameter int unsigned CW = 17
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start_ok,
   input  logic          ls_tick,
   input  logic [CW-1:0] wu_len,
   input  logic [CW-1:0] lk_len,
   input  logic [CW-1:0] end_len,
   input  logic          slow,
   output logic          running,
   output logic          wu_end,
   output logic          lock_busy,
   output logic          done
);
   logic [CW-1:0] cnt, wu_len_q, lk_len_q, end_len_q;
   logic          slow_q;
   logic [CW-1:0] cnt_nx;
   logic          adv;

   assign cnt_nx = cnt + CW'(1);
   assign adv    = running && (!slow_q || ls_tick);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt       <= '0;
         wu_len_q  <= '0;
         lk_len_q  <= '0;
         end_len_q <= '0;
         slow_q    <= 1'b0;
         running   <= 1'b0;
         wu_end    <= 1'b0;
         lock_busy <= 1'b0;
         done      <= 1'b0;
      end else begin
         done <= 1'b0;
         if (start_ok) begin
            cnt       <= '0;
            wu_len_q  <= wu_len;
            lk_len_q  <= lk_len;
            end_len_q <= end_len;
            slow_q    <= slow;
            running   <= 1'b1;
            wu_end    <= 1'b0;
            lock_busy <= 1'b1;
         end else if (adv) begin
            cnt <= cnt_nx;
            if (cnt_nx == wu_len_q) wu_end    <= 1'b1;
            if (cnt_nx == lk_len_q) lock_busy <= 1'b0;
            if (cnt_nx == end_len_q) begin
               done    <= 1'b1;
               running <= 1'b0;
            end
         end
      end
   end
endmodule

// File: rtl/osc_warmup_timer.sv
module osc_warmup_timer #(
   parameter int unsigned WU_E1 = 8,
   parameter int unsigned WU_E2 = 14,
   parameter int unsigned WU_E3 = 16,
   parameter int unsigned LK_E0 = 16,
   parameter int unsigned LK_E1 = 12,
   parameter int unsigned LS_E  = 2,
   parameter bit          LS_ENABLE = 1'b1,
   parameter logic [1:0]  WU_RST = 2'b10
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       ls_tick,
   input  logic       pll_bypass,
   input  logic       sw_start,
   input  logic       hw_start,
   input  logic       wu_sel_we,
   input  logic [1:0] wu_sel_wd,
   input  logic       lk_sel_we,
   input  logic       lk_sel_wd,
   output logic [1:0] wu_sel_q,
   output logic       lk_sel_q,
   output logic       wu_end,
   output logic       lock_busy,
   output logic       done,
   output logic       cfg_err
);
   import wut_pkg::*;
   localparam int unsigned EMAX = max2(max2(max2(WU_E1, WU_E2), max2(WU_E3, LK_E0)),
                                       max2(LK_E1, LS_E));
   localparam int unsigned CW = EMAX + 1;

   initial begin
      assert (EMAX < 31) else $error("length exponent too large");
      assert (WU_E1 > 0 && LK_E1 > 0 && LK_E0 > 0 && LS_E > 0) else $error("zero length exponent");
   end

   logic          running;
   logic          start_ok;
   logic [CW-1:0] wu_len, lk_len, end_len;
   logic          slow;

   assign start_ok = (sw_start || hw_start) && !running && !lock_busy;

   wut_cfg #(.WU_RST(WU_RST), .LK_RST(1'b0)) u_cfg (
      .clk(clk), .rst_n(rst_n), .busy(running),
      .wu_we(wu_sel_we), .wu_wd(wu_sel_wd),
      .lk_we(lk_sel_we), .lk_wd(lk_sel_wd),
      .wu_q(wu_sel_q), .lk_q(lk_sel_q), .err_q(cfg_err)
   );

   wut_len #(
      .WU_E1(WU_E1), .WU_E2(WU_E2), .WU_E3(WU_E3),
      .LK_E0(LK_E0), .LK_E1(LK_E1), .LS_E(LS_E),
      .LS_ENABLE(LS_ENABLE), .CW(CW)
   ) u_len (
      .wu_code(wu_sel_q), .lk_code(lk_sel_q), .bypass(pll_bypass),
      .wu_len(wu_len), .lk_len(lk_len), .end_len(end_len), .slow(slow)
   );

   wut_cnt #(.CW(CW)) u_cnt (
      .clk(clk), .rst_n(rst_n), .start_ok(start_ok), .ls_tick(ls_tick),
      .wu_len(wu_len), .lk_len(lk_len), .end_len(end_len), .slow(slow),
      .running(running), .wu_end(wu_end), .lock_busy(lock_busy), .done(done)
   );
endmodule

// File: rtl/osc_warmup_chk.sv
module osc_warmup_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       start_ok,
   input logic       running,
   input logic [1:0] wu_sel_q,
   input logic       wu_end,
   input logic       lock_busy,
   input logic       done,
   input logic       cfg_err
);
   a_r7_done_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
   a_r7_done_flags: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (wu_end && !lock_busy && !running));
   a_r9_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_err |=> cfg_err);
   a_r9_field_frozen: assert property (@(posedge clk) disable iff (!rst_n)
      $past(running) |-> $stable(wu_sel_q));
   a_r2_busy_rise_on_start: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(lock_busy) |-> $past(start_ok));
   a_r8_wu_end_fall_on_start: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(wu_end) |-> $past(start_ok));
endmodule

bind osc_warmup_timer osc_warmup_chk u_chk (
   .clk(clk), .rst_n(rst_n), .start_ok(start_ok), .running(running),
   .wu_sel_q(wu_sel_q), .wu_end(wu_end), .lock_busy(lock_busy),
   .done(done), .cfg_err(cfg_err)
);

// File: tb/tb_osc_warmup_timer.sv
module tb_osc_warmup_timer;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic ls_tick = 1'b0, pll_bypass = 1'b0, sw_start = 1'b0, hw_start = 1'b0;
   logic wu_sel_we = 1'b0, lk_sel_we = 1'b0, lk_sel_wd = 1'b0;
   logic [1:0] wu_sel_wd = 2'b00;
   logic [1:0] wu_sel_q;
   logic lk_sel_q, wu_end, lock_busy, done, cfg_err;
   int checks = 0, failures = 0;
   bit finished = 1'b0;

   always #4 clk = ~clk;

   osc_warmup_timer #(.WU_E1(3), .WU_E2(5), .WU_E3(6), .LK_E0(6), .LK_E1(4), .LS_E(2)) dut (
      .clk(clk), .rst_n(rst_n), .ls_tick(ls_tick), .pll_bypass(pll_bypass),
      .sw_start(sw_start), .hw_start(hw_start),
      .wu_sel_we(wu_sel_we), .wu_sel_wd(wu_sel_wd),
      .lk_sel_we(lk_sel_we), .lk_sel_wd(lk_sel_wd),
      .wu_sel_q(wu_sel_q), .lk_sel_q(lk_sel_q), .wu_end(wu_end),
      .lock_busy(lock_busy), .done(done), .cfg_err(cfg_err)
   );

   // {wu[1:0], lk, bypass, tick_period[3:0], wu_edge[7:0], lock_edge[7:0], done_edge[7:0]}
   localparam int NV = 10;
   localparam logic [31:0] VEC [NV] = '{
      {2'b01, 1'b0, 1'b0, 4'd0, 8'd8,  8'd64, 8'd64},
      {2'b01, 1'b1, 1'b0, 4'd0, 8'd8,  8'd16, 8'd16},
      {2'b10, 1'b1, 1'b0, 4'd0, 8'd32, 8'd16, 8'd32},
      {2'b11, 1'b0, 1'b0, 4'd0, 8'd64, 8'd64, 8'd64},
      {2'b10, 1'b0, 1'b1, 4'd0, 8'd32, 8'd32, 8'd32},
      {2'b11, 1'b1, 1'b1, 4'd0, 8'd64, 8'd64, 8'd64},
      {2'b01, 1'b0, 1'b1, 4'd0, 8'd8,  8'd8,  8'd8},
      {2'b00, 1'b1, 1'b1, 4'd3, 8'd12, 8'd12, 8'd12},
      {2'b01, 1'b1, 1'b0, 4'd3, 8'd8,  8'd16, 8'd16},
      {2'b00, 1'b1, 1'b0, 4'd3, 8'd12, 8'd48, 8'd48}
   };

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic run(input logic [31:0] v, input bit use_hw, input int inj_k);
      int first_wu = -1, first_lk = -1, first_dn = -1, dn_cycles = 0;
      int per = int'(v[27:24]);
      @(negedge clk);
      wu_sel_we = 1'b1; wu_sel_wd = v[31:30]; lk_sel_we = 1'b1; lk_sel_wd = v[29];
      @(negedge clk);
      wu_sel_we = 1'b0; lk_sel_we = 1'b0; pll_bypass = v[28];
      if (use_hw) hw_start = 1'b1; else sw_start = 1'b1;
      @(posedge clk);
      @(negedge clk);
      sw_start = 1'b0; hw_start = 1'b0;
      chk(wu_end == 1'b0 && lock_busy == 1'b1, "R2 start flags", {wu_end, lock_busy}, 1);
      for (int k = 1; k <= 140; k++) begin
         ls_tick = (per != 0) && ((k % per) == 0);
         if (k == inj_k) begin
            sw_start = 1'b1; wu_sel_we = 1'b1; wu_sel_wd = ~wu_sel_q;
         end
         @(posedge clk);
         @(negedge clk);
         sw_start = 1'b0; wu_sel_we = 1'b0;
         if (wu_end && first_wu < 0) first_wu = k;
         if (!lock_busy && first_lk < 0) first_lk = k;
         if (done && first_dn < 0) first_dn = k;
         if (done) dn_cycles++;
      end
      ls_tick = 1'b0;
      chk(first_wu == int'(v[23:16]), (per == 3 && v[31:30] == 2'b00) ? "R4 low-speed warm-up edge" : "R3 warm-up edge",
          first_wu, int'(v[23:16]));
      chk(first_lk == int'(v[15:8]), v[28] ? "R6 bypass lock clear edge" : "R5 lock clear edge",
          first_lk, int'(v[15:8]));
      chk(first_dn == int'(v[7:0]), "R7 done edge", first_dn, int'(v[7:0]));
      chk(dn_cycles == 1, "R7 done width", dn_cycles, 1);
      chk(wu_end == 1'b1 && lock_busy == 1'b0, "R10 flags held after done", {wu_end, lock_busy}, 2);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      chk(wu_end == 0 && lock_busy == 0 && done == 0 && cfg_err == 0, "R1 flags at reset",
          {wu_end, lock_busy, done, cfg_err}, 0);
      chk(wu_sel_q == 2'b10 && lk_sel_q == 1'b0, "R1 field defaults", {wu_sel_q, lk_sel_q}, 4);
      rst_n = 1'b1;
      @(negedge clk);
      for (int i = 0; i < NV; i++) run(VEC[i], (i % 2) == 1, 0);
      chk(cfg_err == 1'b0, "R9 idle writes set no error", cfg_err, 0);
      chk(wu_sel_q == 2'b00, "R9 idle write accepted", wu_sel_q, 0);
      // mid-run start and field write at edge 20: timing unchanged, write refused
      run(VEC[0], 1'b0, 20);
      chk(wu_sel_q == 2'b01, "R9 busy write ignored", wu_sel_q, 1);
      chk(cfg_err == 1'b1, "R9 busy write sets error", cfg_err, 1);
      repeat (3) @(negedge clk);
      chk(cfg_err == 1'b1, "R9 error sticky", cfg_err, 1);
      // R8: run VEC[1] with a start injected at edge 12, after wu_end is set
      run(VEC[1], 1'b1, 12);
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         failures++;
         $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end
endmodule